// File: doc/BRIEF.md
# Start-Armed Pulse Decimator

This block divides down a stream of short, periodic pulses that arrive from outside the chip. Nothing is counted until a start strobe arms the block. Once armed, it counts rising edges of the external pulse line. When the number of edges equals a programmed 16-bit target, it raises a single-cycle output strobe and falls back to waiting for the next start.

The external line is asynchronous to the system clock and is treated only as data. It passes through a flop synchronizer. A rising-edge detector then turns each pulse into one qualify strobe, however many clock cycles the pulse spans. The target is captured when the block arms, so a host can load the next value while a run is still in progress. A typical use is gating a downstream sequencer after every Nth trigger of a 100 kHz source, with N up to 65535.

Top module: `pulse_decimator`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block returns to the waiting state, its pulse counter is cleared and `done_pulse` is 0 after that edge.
- R2: In the waiting state, pulses on `pulse_in` have no effect: without a `start` strobe, `done_pulse` never rises.
- R3: After `start` is seen high at one clock edge, `done_pulse` rises exactly once, after the Nth rising edge of `pulse_in`, where N is `count_val` (unsigned). It does not rise after fewer edges.
- R4: `done_pulse` is high for exactly one clock cycle each time it rises.
- R5: After `done_pulse`, the block is back in the waiting state. Further pulses produce no output until the next `start`.
- R6: Each pulse counts once, whatever its width: a pulse held high for 20 clock cycles advances the count by one.
- R7: A `count_val` of 0 is treated as 1, so the first pulse after arming completes the run.
- R8: A `start` strobe during a run is ignored. The run is not restarted and completes at its original target.
- R9: `count_val` is captured at arming. Changing it during a run does not move the completion point.
- R10: Large targets are honoured without wrap: with `count_val` = 300, no output comes after 299 pulses and one comes after the 300th.
- R11: A reset in the middle of a run discards the edges already counted. A new run needs the full target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the only clock in the block |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Arm strobe; sampled on the clock |
| pulse_in | input | 1 | Asynchronous external pulse line |
| count_val | input | 16 | Number of pulses per output strobe (0 acts as 1) |
| done_pulse | output | 1 | One-cycle strobe when the target is reached |

## Verification
The hardest situations to reach from the ports are the ones inside a run: a second `start`, a changed `count_val`, or a reset arriving after some edges are counted but before the target. The completion point is the only visible trace of the internal count. The directed tasks therefore stop partway through a run, apply the disturbance, and then send exactly the number of pulses that separates a correct design from one that restarted or reloaded. A strobe that arrives one pulse early or late shows the fault. Wide pulses lasting many clock cycles are also driven, so that a missing edge detector shows up as an early completion.

// File: rtl/pdec_pkg.sv
// Shared types for the start-armed pulse decimator.
// Assumes: nothing beyond a single system clock domain.
package pdec_pkg;
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_COUNT = 1'b1
    } pdec_state_e;
endpackage

// File: rtl/pdec_sync_edge.sv
// Brings an asynchronous level into the clock domain through a flop chain
// and emits a one-cycle strobe on each low-to-high transition.
// Assumes: the input stays high and low for at least two clock cycles each.
module pdec_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_o
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            // Purpose: one synchronizer flop; stage 0 samples the raw line.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain_q[gi] <= 1'b0;
                end else if (gi == 0) begin
                    chain_q[gi] <= async_in;
                end else begin
                    chain_q[gi] <= chain_q[(gi == 0) ? 0 : gi-1];
                end
            end
        end
    endgenerate

    // Purpose: remember the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= 1'b0;
        end else begin
            last_q <= chain_q[STAGES-1];
        end
    end

    assign rise_o = chain_q[STAGES-1] & ~last_q;

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o); // R6
endmodule

// File: rtl/pdec_counter.sv
// Two-state run controller: waits for start, captures the target, counts
// qualify strobes and emits a one-cycle done strobe at the target.
// Assumes: tick_i is a single-cycle strobe, never high two cycles in a row.
module pdec_counter
    import pdec_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] count_val_i,
    output logic             done_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    pdec_state_e      state_q;
    logic [CNT_W-1:0] target_q;
    logic [CNT_W-1:0] seen_q;
    logic [CNT_W-1:0] target_in;
    logic             last_tick;

    // Purpose: map a zero request onto a single-pulse run.
    always_comb begin
        target_in = (count_val_i == '0) ? ONE : count_val_i;
    end

    assign last_tick = tick_i && (seen_q == target_q - ONE);

    // Purpose: state, captured target, pulse count and done strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            target_q <= ONE;
            seen_q   <= '0;
            done_o   <= 1'b0;
        end else begin
            done_o <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    seen_q <= '0;
                    if (start_i) begin
                        target_q <= target_in;
                        state_q  <= ST_COUNT;
                    end
                end
                default: begin
                    if (last_tick) begin
                        done_o  <= 1'b1;
                        seen_q  <= '0;
                        state_q <= ST_IDLE;
                    end else if (tick_i) begin
                        seen_q <= seen_q + ONE;
                    end
                end
            endcase
        end
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R4
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !start_i) |=> (state_q == ST_IDLE && !done_o)); // R2
    AST_TARGET_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COUNT) |=> (state_q == ST_IDLE || $stable(target_q))); // R9
    AST_TARGET_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COUNT) |-> (target_q != '0)); // R7
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COUNT) |-> (seen_q < target_q)); // R10
    AST_DONE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (state_q == ST_IDLE)); // R5
endmodule

// File: rtl/pulse_decimator.sv
// Top of the start-armed pulse decimator: synchronizer and edge detector
// in front of the run controller.
// Assumes: pulse_in pulses span at least two clock cycles high and low.
module pulse_decimator #(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             pulse_in,
    input  logic [CNT_W-1:0] count_val,
    output logic             done_pulse
);
    logic tick;

    pdec_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pulse_in),
        .rise_o   (tick)
    );

    pdec_counter #(.CNT_W(CNT_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .tick_i      (tick),
        .count_val_i (count_val),
        .done_o      (done_pulse)
    );
endmodule

// File: tb/sim_pulse_decimator.sv
module sim_pulse_decimator;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        pulse_in = 1'b0;
    logic [15:0] count_val = 16'd5;
    logic        done_pulse;

    int n_total = 0;
    int n_fail  = 0;
    int done_cnt = 0;
    int run_len = 0;
    int max_len = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    pulse_decimator u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .pulse_in   (pulse_in),
        .count_val  (count_val),
        .done_pulse (done_pulse)
    );

    // Count done strobes and their widths away from the active edge.
    always @(negedge clk) begin
        if (done_pulse === 1'b1) begin
            if (run_len == 0) done_cnt++;
            run_len++;
            if (run_len > max_len) max_len = run_len;
        end else begin
            run_len = 0;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    endtask

    task automatic do_reset;
        @(negedge clk) rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic arm;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic send(input int hi);
        @(negedge clk) pulse_in = 1'b1;
        repeat (hi) @(negedge clk);
        pulse_in = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic sends(input int n);
        for (int i = 0; i < n; i++) send(4);
    endtask

    task automatic t_reset;
        do_reset();
        @(negedge clk);
        check(done_pulse == 1'b0, "R1 done low after reset", done_pulse, 0);
    endtask

    task automatic t_idle_ignored;
        int base = done_cnt;
        count_val = 16'd1;
        sends(3);
        check(done_cnt == base, "R2 pulses ignored while waiting", done_cnt - base, 0);
    endtask

    task automatic t_basic;
        int base = done_cnt;
        count_val = 16'd5;
        arm();
        sends(4);
        check(done_cnt == base, "R3 no done before target", done_cnt - base, 0);
        sends(1);
        check(done_cnt == base + 1, "R3 done at target", done_cnt - base, 1);
        sends(3);
        check(done_cnt == base + 1, "R5 back to waiting after done", done_cnt - base, 1);
    endtask

    task automatic t_wide;
        int base = done_cnt;
        count_val = 16'd2;
        arm();
        send(20);
        check(done_cnt == base, "R6 wide pulse counts once", done_cnt - base, 0);
        send(20);
        check(done_cnt == base + 1, "R6 second wide pulse completes", done_cnt - base, 1);
    endtask

    task automatic t_zero;
        int base = done_cnt;
        count_val = 16'd0;
        arm();
        sends(1);
        check(done_cnt == base + 1, "R7 zero target acts as one", done_cnt - base, 1);
    endtask

    task automatic t_restart;
        int base = done_cnt;
        count_val = 16'd4;
        arm();
        sends(2);
        arm();
        sends(2);
        check(done_cnt == base + 1, "R8 start during run ignored", done_cnt - base, 1);
    endtask

    task automatic t_latch;
        int base = done_cnt;
        count_val = 16'd3;
        arm();
        sends(1);
        count_val = 16'd10;
        sends(2);
        check(done_cnt == base + 1, "R9 target captured at arming", done_cnt - base, 1);
    endtask

    task automatic t_large;
        int base = done_cnt;
        count_val = 16'd300;
        arm();
        sends(299);
        check(done_cnt == base, "R10 no done after 299 of 300", done_cnt - base, 0);
        sends(1);
        check(done_cnt == base + 1, "R10 done after 300", done_cnt - base, 1);
    endtask

    task automatic t_mid_reset;
        int base = done_cnt;
        count_val = 16'd4;
        arm();
        sends(3);
        do_reset();
        check(done_pulse == 1'b0, "R11 output clear after reset", done_pulse, 0);
        arm();
        sends(3);
        check(done_cnt == base, "R11 count discarded by reset", done_cnt - base, 0);
        sends(1);
        check(done_cnt == base + 1, "R11 full target after reset", done_cnt - base, 1);
    endtask

    initial begin
        t_reset();
        t_idle_ignored();
        t_basic();
        t_wide();
        t_zero();
        t_restart();
        t_latch();
        t_large();
        t_mid_reset();
        check(max_len == 1, "R4 done one cycle wide", max_len, 1);
        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            check(1'b0, "watchdog expired", 0, 1);
            summary();
            $finish;
        end
    end
endmodule